// File: doc/BRIEF.md
# Sub-word access adapter for a dword-only register target

This block sits between a requester and a register target. The requester issues reads and writes of 1, 2 or 4 bytes at any byte address. The target only accepts whole, 32-bit aligned transfers and has no byte enables. The adapter checks each request. It turns a legal request into one or two dword transfers on the target side and returns a single response to the requester.

For a narrow read, the adapter fetches the dword that contains the address. It moves the addressed lanes down to bit 0 and clears every bit above the access width. A full-width write goes straight through as one target write. A byte or halfword write is done as read-modify-write. The adapter fetches the dword, replaces only the addressed lanes with the low bits of the write data, and writes the whole dword back. A request with an illegal size, or an address that is not aligned to its size, never reaches the target. It is answered at once with an error flag.

Only one request is in flight at a time. The requester sees its response only after the last target transfer belonging to that request has completed.

Top module: `subword_bridge`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `tgt_valid_o` are 0. A new request is accepted only after the previous response has been taken.
- R2: `req_size_i` holds the byte count. Only 1, 2 and 4 are legal. Any other value gives a response with `rsp_err_o`=1 and makes no target transfer.
- R3: A 2-byte request with `req_addr_i[0]`=1, or a 4-byte request with `req_addr_i[1:0]`≠0, gives an error response and makes no target transfer.
- R4: An error response to a read carries `rsp_rdata_o`=32'hFFFF_FFFF. An error response to a write carries 0.
- R5: Every target transfer uses `tgt_addr_o` equal to the request address with bits [1:0] cleared.
- R6: Read data equals the target dword shifted right by 8 × `req_addr_i[1:0]`. It is then cut to 8 bits for size 1 or 16 bits for size 2, with all higher bits zero.
- R7: A 4-byte write makes exactly one target transfer, a write of `req_wdata_i`, and no target read.
- R8: A 1- or 2-byte write makes one target read, then one target write. That write replaces only the addressed byte lanes with the low 8 or 16 bits of `req_wdata_i` and keeps the other lanes unchanged. Upper write-data bits are ignored.
- R9: A legal read makes exactly one target read and no target write. The write response data is 0, and `rsp_err_o` is 0 for legal requests.
- R10: While `tgt_valid_o` is 1 and `tgt_ready_i` is 0, the adapter keeps `tgt_valid_o`, `tgt_write_o`, `tgt_addr_o` and `tgt_wdata_o` unchanged.
- R11: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the adapter keeps `rsp_valid_o`, `rsp_rdata_o` and `rsp_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Adapter can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | SIZE_W | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| rsp_err_o | output | 1 | Request rejected |
| tgt_valid_o | output | 1 | Target transfer present |
| tgt_ready_i | input | 1 | Target takes the transfer |
| tgt_write_o | output | 1 | 1 = dword write, 0 = dword read |
| tgt_addr_o | output | ADDR_W | Dword-aligned byte address |
| tgt_wdata_o | output | 32 | Dword write data |
| tgt_rvalid_i | input | 1 | Target finished a transfer (read data valid) |
| tgt_rdata_i | input | 32 | Dword read data |

## Verification
The latched lane select drives both the read extraction and the write merge. If it is wrong, a read returns bytes from the wrong lane, or a narrow write corrupts a neighbouring lane. The corruption is silent until that dword is read back, so the bench compares the whole target memory with its byte-addressed reference at the end, not only the responses. If the sequencer is in the wrong state, the number of target reads and writes for one request is wrong. The bench counts these per request and checks them when the response appears. An error request that leaks to the target shows up in the same count before its response is taken. The target and requester handshakes are stalled on fixed cycle patterns, so the hold requirements are checked in the cycle right after each stall.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WORD_B = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(WORD_B);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RSP
  } sbw_state_e;
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
  import sbw_pkg::*;
#(
  parameter int unsigned SIZE_W = 3
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              err_o,
  output logic              full_o,
  output logic [WORD_B-1:0] lane_sel_o
);
  localparam logic [WORD_B-1:0] SEL_B = WORD_B'(1);
  localparam logic [WORD_B-1:0] SEL_H = WORD_B'(3);

  always_comb begin
    err_o      = 1'b1;
    full_o     = 1'b0;
    lane_sel_o = '0;
    if (size_i == SIZE_W'(1)) begin
      err_o      = 1'b0;
      lane_sel_o = SEL_B << ofs_i;
    end else if (size_i == SIZE_W'(2)) begin
      err_o      = ofs_i[0];
      lane_sel_o = SEL_H << ofs_i;
    end else if (size_i == SIZE_W'(WORD_B)) begin
      err_o      = |ofs_i;
      full_o     = 1'b1;
      lane_sel_o = '1;
    end
  end
endmodule

// File: rtl/sbw_lane.sv
module sbw_lane
  import sbw_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_B-1:0] lane_sel_i,
  output logic [WORD_W-1:0] rd_o,
  output logic [WORD_W-1:0] merged_o
);
  logic [WORD_W-1:0]   bit_mask;
  logic [WORD_W-1:0]   ins;
  logic [OFS_W+2:0]    shamt;

  assign shamt = {ofs_i, 3'b000};
  assign ins   = wdata_i << shamt;

  for (genvar g = 0; g < WORD_B; g++) begin : g_lane
    assign bit_mask[8*g +: 8] = {8{lane_sel_i[g]}};
    assign merged_o[8*g +: 8] = lane_sel_i[g] ? ins[8*g +: 8] : old_i[8*g +: 8];
  end

  assign rd_o = (old_i & bit_mask) >> shamt;
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic       req_err_i,
  input  logic       req_full_i,
  input  logic       lat_write_i,
  input  logic       tgt_ready_i,
  input  logic       tgt_rvalid_i,
  input  logic       rsp_ready_i,
  output sbw_state_e state_o,
  output logic       req_ready_o,
  output logic       tgt_valid_o,
  output logic       tgt_write_o,
  output logic       rsp_valid_o
);
  sbw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_err_i)                    state_d = ST_RSP;
        else if (req_write_i && req_full_i) state_d = ST_WR_REQ;
        else                              state_d = ST_RD_REQ;
      end
      ST_RD_REQ:  if (tgt_ready_i)  state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (tgt_rvalid_i) state_d = lat_write_i ? ST_WR_REQ : ST_RSP;
      ST_WR_REQ:  if (tgt_ready_i)  state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (tgt_rvalid_i) state_d = ST_RSP;
      ST_RSP:     if (rsp_ready_i)  state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign tgt_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign tgt_write_o = (state_q == ST_WR_REQ);
  assign rsp_valid_o = (state_q == ST_RSP);

  AST_RSP_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o); // R11
  AST_TGT_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !tgt_ready_i |=> tgt_valid_o && $stable(tgt_write_o)); // R10
  AST_ACCEPT_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> $past(rsp_valid_o && rsp_ready_i)); // R1
endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  output logic              tgt_write_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [WORD_W-1:0] tgt_wdata_o,
  input  logic              tgt_rvalid_i,
  input  logic [WORD_W-1:0] tgt_rdata_i
);
  sbw_state_e        state;
  logic              req_fire;
  logic              dec_err, dec_full;
  logic [WORD_B-1:0] dec_sel;

  logic [ADDR_W-1:0] lat_addr;
  logic [WORD_W-1:0] lat_wdata;
  logic [WORD_B-1:0] lat_sel;
  logic              lat_write, lat_err, lat_full;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rsp_data;
  logic              rsp_err;
  logic [WORD_W-1:0] rd_val, merged;

  sbw_decode #(.SIZE_W(SIZE_W)) u_dec (
    .ofs_i      (req_addr_i[OFS_W-1:0]),
    .size_i     (req_size_i),
    .err_o      (dec_err),
    .full_o     (dec_full),
    .lane_sel_o (dec_sel)
  );

  sbw_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_err_i    (dec_err),
    .req_full_i   (dec_full),
    .lat_write_i  (lat_write),
    .tgt_ready_i  (tgt_ready_i),
    .tgt_rvalid_i (tgt_rvalid_i),
    .rsp_ready_i  (rsp_ready_i),
    .state_o      (state),
    .req_ready_o  (req_ready_o),
    .tgt_valid_o  (tgt_valid_o),
    .tgt_write_o  (tgt_write_o),
    .rsp_valid_o  (rsp_valid_o)
  );

  sbw_lane u_lane (
    .old_i      (tgt_rdata_i),
    .wdata_i    (lat_wdata),
    .ofs_i      (lat_addr[OFS_W-1:0]),
    .lane_sel_i (lat_sel),
    .rd_o       (rd_val),
    .merged_o   (merged)
  );

  assign req_fire = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_sel   <= '0;
      lat_write <= 1'b0;
      lat_err   <= 1'b0;
      lat_full  <= 1'b0;
    end else if (req_fire) begin
      lat_addr  <= req_addr_i;
      lat_wdata <= req_wdata_i;
      lat_sel   <= dec_sel;
      lat_write <= req_write_i;
      lat_err   <= dec_err;
      lat_full  <= dec_full;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_word  <= '0;
      rsp_data <= '0;
      rsp_err  <= 1'b0;
    end else if (req_fire) begin
      rsp_err  <= dec_err;
      rsp_data <= (dec_err && !req_write_i) ? '1 : '0;
      if (req_write_i && dec_full) wr_word <= req_wdata_i;
    end else if (tgt_rvalid_i && state == ST_RD_WAIT) begin
      if (lat_write) wr_word  <= merged;
      else           rsp_data <= rd_val;
    end else if (tgt_rvalid_i && state == ST_WR_WAIT) begin
      rsp_data <= '0;
    end
  end

  assign tgt_addr_o  = {lat_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign tgt_wdata_o = wr_word;
  assign rsp_rdata_o = rsp_data;
  assign rsp_err_o   = rsp_err;

  AST_TGT_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !tgt_ready_i |=> $stable(tgt_addr_o) && $stable(tgt_wdata_o)); // R10
  AST_RSP_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> $stable(rsp_rdata_o) && $stable(rsp_err_o)); // R11
  AST_ERR_RD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o && !lat_write |-> rsp_rdata_o == '1); // R4
  AST_NARROW_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o && !lat_write && $countones(lat_sel) == 1
    |-> rsp_rdata_o[WORD_W-1:8] == '0); // R6
  AST_FULL_WR_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o && !tgt_write_o |-> !(lat_write && lat_full)); // R7
  AST_NO_ACCESS_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> !lat_err); // R2
endmodule

// File: tb/subword_bridge_tb.sv
module subword_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_rdata_o;
  logic        rsp_err_o;
  logic        tgt_valid_o;
  logic        tgt_ready_i = 1'b0;
  logic        tgt_write_o;
  logic [15:0] tgt_addr_o;
  logic [31:0] tgt_wdata_o;
  logic        tgt_rvalid_i = 1'b0;
  logic [31:0] tgt_rdata_i = '0;

  always #5 clk = ~clk;

  subword_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o),
    .rsp_err_o(rsp_err_o), .tgt_valid_o(tgt_valid_o), .tgt_ready_i(tgt_ready_i),
    .tgt_write_o(tgt_write_o), .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o),
    .tgt_rvalid_i(tgt_rvalid_i), .tgt_rdata_i(tgt_rdata_i)
  );

  typedef struct {
    logic        err;
    logic [31:0] data;
    int          nrd;
    int          nwr;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  ref_mem [256];
  logic [31:0] tmem [64];
  int          total = 0;
  int          bad = 0;
  int          cnt_rd = 0;
  int          cnt_wr = 0;
  int          cyc = 0;
  int          t_cnt = 0;
  logic [31:0] t_rd = '0;
  logic        done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic        rsp_stall = 1'b0;
  logic [31:0] rsp_prev_d = '0;
  logic        rsp_prev_e = 1'b0;
  logic        tgt_stall = 1'b0;
  logic [15:0] tgt_prev_a = '0;
  logic [31:0] tgt_prev_d = '0;
  logic        tgt_prev_w = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Driver: builds the expected item from the byte reference, then handshakes
  task automatic issue(input bit wr, input logic [15:0] addr, input logic [2:0] size,
                       input logic [31:0] wdata, input string tag);
    exp_t e;
    bit   ok;
    logic [1:0] ofs;
    ofs = addr[1:0];
    ok = (size == 3'd1) || (size == 3'd2 && !addr[0]) || (size == 3'd4 && ofs == 2'd0);
    e.tag = tag;
    if (!ok) begin
      e.err = 1'b1; e.data = wr ? 32'h0 : 32'hFFFF_FFFF; e.nrd = 0; e.nwr = 0;
    end else if (!wr) begin
      e.err = 1'b0; e.data = '0; e.nrd = 1; e.nwr = 0;
      for (int b = 0; b < int'(size); b++) e.data[8*b +: 8] = ref_mem[(int'(addr) + b) & 255];
    end else begin
      for (int b = 0; b < int'(size); b++) ref_mem[(int'(addr) + b) & 255] = wdata[8*b +: 8];
      e.err = 1'b0; e.data = '0; e.nrd = (size == 3'd4) ? 0 : 1; e.nwr = 1;
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_size_i = size; req_wdata_i = wdata;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_wdata_i = rnd();
  endtask

  // Monitor and dword-only target model
  always @(negedge clk) begin
    if (rst_ni) begin
      exp_t e;
      cyc++;
      if (rsp_stall)
        check(rsp_valid_o && rsp_rdata_o == rsp_prev_d && rsp_err_o == rsp_prev_e,
              "R11 rsp hold", rsp_rdata_o, rsp_prev_d);
      rsp_ready_i = (cyc % 4 != 1);
      if (rsp_valid_o && rsp_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected response", rsp_rdata_o, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(rsp_err_o == e.err, {e.tag, " err"}, {31'h0, rsp_err_o}, {31'h0, e.err});
          check(rsp_rdata_o == e.data, {e.tag, " data"}, rsp_rdata_o, e.data);
          check(cnt_rd == e.nrd, {e.tag, " target reads"}, cnt_rd, e.nrd);
          check(cnt_wr == e.nwr, {e.tag, " target writes"}, cnt_wr, e.nwr);
        end
        cnt_rd = 0; cnt_wr = 0;
      end
      rsp_stall  = rsp_valid_o && !rsp_ready_i;
      rsp_prev_d = rsp_rdata_o;
      rsp_prev_e = rsp_err_o;

      if (tgt_rvalid_i) tgt_rvalid_i = 1'b0;
      if (t_cnt > 0) begin
        t_cnt--;
        if (t_cnt == 0) begin tgt_rvalid_i = 1'b1; tgt_rdata_i = t_rd; end
      end
      if (tgt_stall)
        check(tgt_valid_o && tgt_addr_o == tgt_prev_a && tgt_wdata_o == tgt_prev_d &&
              tgt_write_o == tgt_prev_w, "R10 target hold", {16'h0, tgt_addr_o}, {16'h0, tgt_prev_a});
      tgt_ready_i = (cyc % 3 != 0);
      if (tgt_valid_o && tgt_ready_i) begin
        if (tgt_addr_o[1:0] != 2'b00)
          check(1'b0, "R5 unaligned target address", {16'h0, tgt_addr_o}, {16'h0, tgt_addr_o & 16'hFFFC});
        if (tgt_write_o) begin
          tmem[tgt_addr_o[7:2]] = tgt_wdata_o; cnt_wr++; t_rd = '0;
        end else begin
          t_rd = tmem[tgt_addr_o[7:2]]; cnt_rd++;
        end
        t_cnt = 1 + (cyc % 2);
      end
      tgt_stall  = tgt_valid_o && !tgt_ready_i;
      tgt_prev_a = tgt_addr_o;
      tgt_prev_d = tgt_wdata_o;
      tgt_prev_w = tgt_write_o;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      tmem[i] = 32'h0101_0101 * i + 32'h3C5A_9600;
      for (int b = 0; b < 4; b++) ref_mem[4*i + b] = tmem[i][8*b +: 8];
    end
    repeat (3) @(negedge clk);
    check(!rsp_valid_o && !tgt_valid_o, "R1 in reset", {30'h0, rsp_valid_o, tgt_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !tgt_valid_o, "R1 reset state",
          {29'h0, req_ready_o, rsp_valid_o, tgt_valid_o}, 32'h4);

    for (int a = 0; a < 4; a++) issue(1'b0, 16'(8 + a), 3'd1, '0, "R6 byte read");
    issue(1'b0, 16'd12, 3'd2, '0, "R6 half read lo");
    issue(1'b0, 16'd14, 3'd2, '0, "R6 half read hi");
    issue(1'b0, 16'd16, 3'd4, '0, "R9 dword read");
    for (int a = 0; a < 4; a++) issue(1'b1, 16'(20 + a), 3'd1, 32'hFFFF_FF00 | 32'(a + 'h41), "R8 byte write");
    issue(1'b1, 16'd26, 3'd2, 32'hDEAD_BEEF, "R8 half write hi");
    issue(1'b1, 16'd24, 3'd2, 32'h1234_CAFE, "R8 half write lo");
    issue(1'b0, 16'd20, 3'd4, '0, "R8 readback");
    issue(1'b0, 16'd24, 3'd4, '0, "R8 readback");
    issue(1'b1, 16'd28, 3'd4, 32'hA5A5_0FF0, "R7 dword write");
    issue(1'b0, 16'd29, 3'd1, '0, "R7 readback");
    issue(1'b0, 16'd4, 3'd0, '0, "R2 size 0 read");
    issue(1'b0, 16'd4, 3'd3, '0, "R2 size 3 read");
    issue(1'b1, 16'd4, 3'd7, 32'h1111_1111, "R2 size 7 write");
    issue(1'b0, 16'd5, 3'd2, '0, "R3 half misaligned read");
    issue(1'b1, 16'd7, 3'd2, 32'h2222_2222, "R3 half misaligned write");
    issue(1'b0, 16'd6, 3'd4, '0, "R4 dword misaligned read");
    issue(1'b1, 16'd1, 3'd4, 32'h3333_3333, "R4 dword misaligned write");
    issue(1'b0, 16'd4, 3'd4, '0, "R3 no write leaked");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [2:0]  sz;
      logic [15:0] ad;
      r = rnd();
      case (r[2:0])
        3'd0, 3'd1, 3'd2: sz = 3'd1;
        3'd3, 3'd4:       sz = 3'd2;
        3'd5, 3'd6:       sz = 3'd4;
        default:          sz = r[5:3];
      endcase
      ad = {8'h0, r[15:8]};
      if (r[20:18] != 3'd0) begin
        if (sz == 3'd2) ad[0] = 1'b0;
        if (sz == 3'd4) ad[1:0] = 2'b00;
      end
      issue(r[16], ad, sz, rnd(), "R6 R8 random");
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 64; i++)
      check(tmem[i] == {ref_mem[4*i+3], ref_mem[4*i+2], ref_mem[4*i+1], ref_mem[4*i]},
            "R8 lanes preserved", tmem[i], {ref_mem[4*i+3], ref_mem[4*i+2], ref_mem[4*i+1], ref_mem[4*i]});
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule